// File: doc/BRIEF.md
# Three-wire serial EEPROM device model

This block is the device end of a three-wire serial memory link. It has a chip select, a serial clock and a data input, and a data output with an enable. Behind that link sits a register-array memory of 256 words of 16 bits. A host raises chip select and clocks in a frame. The frame is a single 1 start bit, then a two-bit opcode, then an eight-bit address, all MSB first. For a write, sixteen data bits follow. The block decodes the frame on rising serial clock edges, sampled in its own system clock domain.

Reads answer with one zero bit and then the addressed word, MSB first. While the clock keeps running they go on through the following addresses, with no further zero bit, and wrap from the top address to 0. A write is committed when chip select falls. It then runs a self-timed program cycle of a fixed number of system clocks. During that cycle the host may raise chip select and poll the output, which reads 0 while busy and 1 once ready. Writes are refused until an enable instruction arrives, and a disable instruction refuses them again. The high-impedance output is modelled as a value plus an enable that is low whenever chip select is low.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high, zeros clocked in before the first 1 are ignored. After the 1 start bit come 2 opcode bits and 8 address bits, MSB first. The opcodes are 10 = read, 01 = write, and 00 = control. Control with address bits [7:6] = 11 enables writes, and control with [7:6] = 00 disables them.
- R2: On the rising serial clock edge that takes the last address bit of a read, do_oe goes to 1 and do_o to 0. Each following rising edge then presents one bit of the addressed word, starting with bit 15.
- R3: After bit 0 of a word, the next rising edge presents bit 15 of the word at the next address, with no zero bit in between. Address 255 is followed by address 0.
- R4: A write takes 16 data bits, MSB first. The falling edge of chip select starts a program cycle of PROG_CYCLES system clocks, after which the location holds the new word. An earlier value at that location does not need to be cleared first.
- R5: While a program cycle runs and chip select is high, do_oe = 1 and do_o = 0. Once the cycle ends, do_o = 1 until chip select falls or a new start bit is taken.
- R6: After reset, writes are disabled. A write received while writes are disabled leaves memory unchanged, and starts no busy period, so do_oe stays 0 when chip select is raised again.
- R7: After a disable instruction, later writes are refused as in R6 until an enable instruction is received.
- R8: do_oe is 0 whenever chip select is low, and also while an instruction is being clocked in.
- R9: Start bits clocked in while a program cycle runs are ignored, so a whole write frame sent during that time changes nothing.
- R10: If chip select falls before all 16 data bits of a write have arrived, nothing is stored and no busy period starts.
- R11: After reset, every location reads 0 and do_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; it samples the serial pins and times the program cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; frames advance on its rising edge |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Data out enable; 0 stands for high impedance |

## Verification
The assertions assume that cs, sk and di are synchronous to clk and that each level of sk lasts at least one system clock. This lets every rising serial edge be seen as exactly one sampled event, and makes a chip-select fall a single-cycle event. The bench changes these pins only on falling system clock edges and holds each half of the serial clock for two system clocks. Chip select is always lowered with sk low, and a frame written during a program cycle is kept shorter than that cycle, so the refusal checks of R9 stay inside the busy window.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [1:0] {
    OP_CTRL  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_OTHER = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_READ,
    ST_WDATA,
    ST_WREADY,
    ST_SKIP
  } st_e;

  // control instruction: top two address bits select the action
  function automatic logic ctrl_enables(input logic [1:0] sel);
    return sel == 2'b11;
  endfunction

  function automatic logic ctrl_disables(input logic [1:0] sel);
    return sel == 2'b00;
  endfunction

endpackage

// File: rtl/mw_edge.sv
module mw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  input  logic cs,
  output logic sk_rise,
  output logic cs_fall
);
  logic sk_q;
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      sk_q <= sk;
      cs_q <= cs;
    end
  end

  assign sk_rise = sk & ~sk_q;
  assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic              busy,
  output logic              ev_store
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [TW-1:0]     tmr;

  assign busy     = (tmr != '0);
  assign ev_store = (tmr == TW'(1));
  assign rd_word  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (launch)    tmr <= TW'(PROG_CYCLES);
      else if (busy) tmr <= tmr - TW'(1);
      if (ev_store)  mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              sk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ev_start,
  output logic              ev_launch,
  output logic              wen,
  output logic              status,
  output logic              rd_active,
  output logic              do_bit
);
  localparam int HW      = 2 + ADDR_W;
  localparam int CNT_MAX = (HW > DATA_W) ? HW : DATA_W;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int IW      = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  st_e              st;
  logic [HW-2:0]    hdr;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    bit_idx;
  logic [HW-1:0]    hdr_full;
  logic [ADDR_W-1:0] hdr_addr;
  op_e              op;
  logic             hdr_last;

  assign hdr_full  = {hdr, di};
  assign op        = op_e'(hdr_full[HW-1 -: 2]);
  assign hdr_addr  = hdr_full[ADDR_W-1:0];
  assign hdr_last  = (st == ST_HDR) && sk_rise && (cnt == CW'(HW - 1));
  assign ev_start  = (st == ST_IDLE) && cs && sk_rise && di && !busy;
  assign ev_launch = cs_fall && (st == ST_WREADY) && wen;
  assign rd_active = (st == ST_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      hdr     <= '0;
      cnt     <= '0;
      bit_idx <= '0;
      rd_addr <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      wen     <= 1'b0;
      status  <= 1'b0;
      do_bit  <= 1'b0;
    end else if (!cs) begin
      st <= ST_IDLE;
      if (cs_fall && !busy) status <= 1'b0;
      if (ev_launch)        status <= 1'b1;
    end else if (sk_rise) begin
      case (st)
        ST_IDLE: begin
          if (ev_start) begin
            st     <= ST_HDR;
            cnt    <= '0;
            status <= 1'b0;
          end
        end
        ST_HDR: begin
          hdr <= hdr_full[HW-2:0];
          cnt <= cnt + CW'(1);
          if (hdr_last) begin
            case (op)
              OP_READ: begin
                st      <= ST_READ;
                rd_addr <= hdr_addr;
                bit_idx <= IW'(DATA_W - 1);
                do_bit  <= 1'b0;
              end
              OP_WRITE: begin
                st      <= ST_WDATA;
                wr_addr <= hdr_addr;
                cnt     <= '0;
              end
              OP_CTRL: begin
                st <= ST_SKIP;
                if (ctrl_enables(hdr_addr[ADDR_W-1 -: 2]))       wen <= 1'b1;
                else if (ctrl_disables(hdr_addr[ADDR_W-1 -: 2])) wen <= 1'b0;
              end
              default: st <= ST_SKIP;
            endcase
          end
        end
        ST_READ: begin
          do_bit <= rd_word[bit_idx];
          if (bit_idx == '0) begin
            bit_idx <= IW'(DATA_W - 1);
            rd_addr <= next_addr(rd_addr);
          end else begin
            bit_idx <= bit_idx - IW'(1);
          end
        end
        ST_WDATA: begin
          wr_data <= {wr_data[DATA_W-2:0], di};
          cnt     <= cnt + CW'(1);
          if (cnt == CW'(DATA_W - 1)) st <= ST_WREADY;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  logic              sk_rise;
  logic              cs_fall;
  logic              busy;
  logic              ev_start;
  logic              ev_launch;
  logic              ev_store;
  logic              wen;
  logic              status;
  logic              rd_active;
  logic              do_bit;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_word;

  mw_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sk     (sk),
    .cs     (cs),
    .sk_rise(sk_rise),
    .cs_fall(cs_fall)
  );

  mw_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .di       (di),
    .sk_rise  (sk_rise),
    .cs_fall  (cs_fall),
    .busy     (busy),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ev_start (ev_start),
    .ev_launch(ev_launch),
    .wen      (wen),
    .status   (status),
    .rd_active(rd_active),
    .do_bit   (do_bit)
  );

  mw_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (ev_launch),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_word (rd_word),
    .busy    (busy),
    .ev_store(ev_store)
  );

  assign do_oe = cs & (rd_active | status);
  assign do_o  = do_oe & (status ? ~busy : do_bit);
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic do_o,
  input logic do_oe,
  input logic ev_start,
  input logic ev_launch,
  input logic ev_store,
  input logic busy,
  input logic wen,
  input logic status
);
  assert_hiz_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !do_oe);

  assert_launch_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |-> wen);

  assert_launch_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> busy);

  assert_busy_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && status && busy) |-> (do_oe && !do_o));

  assert_no_start_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_start);

  assert_store_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> !busy);

  assert_single_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_launch, ev_store}));
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs       (cs),
  .do_o     (do_o),
  .do_oe    (do_oe),
  .ev_start (ev_start),
  .ev_launch(ev_launch),
  .ev_store (ev_store),
  .busy     (busy),
  .wen      (wen),
  .status   (status)
);

// File: tb/mw_eeprom_bench.sv
`timescale 1ns/1ps
module mw_eeprom_bench;
  localparam int PROG = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic do_o;
  logic do_oe;

  int checks = 0;
  int errors = 0;
  logic exp_wen = 1'b0;
  logic [15:0] ref_mem [256];

  always #4 clk = ~clk;

  mw_eeprom #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  function automatic logic exp_bit(input logic [7:0] a, input int w, input int b);
    logic [7:0] aw;
    aw = a + 8'(w);
    return ref_mem[aw][15 - b];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic sk_bit(input logic b);
    @(negedge clk); di = b; sk = 1'b1;
    repeat (2) @(negedge clk);
    sk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_up();
    @(negedge clk); cs = 1'b1;
    @(negedge clk);
  endtask

  task automatic cs_down();
    @(negedge clk); cs = 1'b0; di = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [7:0] a, input int lead);
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = 7; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_ctrl(input logic en);
    logic [7:0] a;
    a = {en ? 2'b11 : 2'b00, 6'($urandom)};
    cs_up(); send_hdr(2'b00, a, 0); cs_down();
    exp_wen = en;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d, input string tag);
    int k;
    cs_up();
    send_hdr(2'b01, a, 0);
    for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    cs_down();
    cs_up();
    if (exp_wen) begin
      chk({tag, " R5 busy oe"}, int'(do_oe), 1);
      chk({tag, " R5 busy level"}, int'(do_o), 0);
      k = 0;
      while (!do_o && k < PROG + 50) begin
        @(negedge clk); k++;
      end
      chk({tag, " R5 ready window"}, int'(k >= PROG - 8 && k <= PROG), 1);
      chk({tag, " R5 ready oe"}, int'(do_oe), 1);
      ref_mem[a] = d;
    end else begin
      chk({tag, " R6 no status"}, int'(do_oe), 0);
    end
    cs_down();
  endtask

  task automatic do_read(input logic [7:0] a, input int nw, input int lead, input string tag);
    cs_up();
    send_hdr(2'b10, a, lead);
    chk({tag, " R2 dummy oe"}, int'(do_oe), 1);
    chk({tag, " R2 dummy zero"}, int'(do_o), 0);
    for (int w = 0; w < nw; w++) begin
      for (int b = 0; b < 16; b++) begin
        sk_bit(1'($urandom));
        chk({tag, (w == 0) ? " R2 data" : " R3 seq data"}, int'(do_o), int'(exp_bit(a, w, b)));
      end
    end
    cs_down();
    chk({tag, " R8 deselect hiz"}, int'(do_oe), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ra;
    logic [15:0] rd;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) ref_mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R11 reset oe", int'(do_oe), 0);
    cs_up();
    chk("R8 idle select oe", int'(do_oe), 0);
    sk_bit(1'b1);
    chk("R8 header oe", int'(do_oe), 0);
    cs_down();
    do_read(8'd0, 2, 0, "R11 reset contents");

    do_write(8'd5, 16'hA5C3, "R6 disabled write");
    do_read(8'd5, 1, 0, "R6 memory kept");

    send_ctrl(1'b1);
    do_write(8'd5, 16'hA5C3, "R4 first write");
    do_read(8'd5, 1, 0, "R4 readback");
    do_write(8'd5, 16'h1234, "R4 overwrite");
    do_read(8'd5, 1, 2, "R1 leading zeros R4 overwrite");

    do_write(8'd255, 16'hBEEF, "R3 top word");
    do_write(8'd0, 16'hCAFE, "R3 bottom word");
    do_read(8'd254, 3, 0, "R3 wrap");

    cs_up();
    send_hdr(2'b01, 8'd9, 0);
    for (int i = 0; i < 8; i++) sk_bit(1'b1);
    cs_down();
    cs_up();
    chk("R10 partial no status", int'(do_oe), 0);
    cs_down();
    do_read(8'd9, 1, 0, "R10 memory kept");

    cs_up();
    send_hdr(2'b01, 8'd20, 0);
    for (int i = 15; i >= 0; i--) sk_bit(1'(16'h5A5A >> i));
    cs_down();
    ref_mem[20] = 16'h5A5A;
    cs_up();
    chk("R9 busy seen", int'(do_oe && !do_o), 1);
    send_hdr(2'b01, 8'd21, 0);
    for (int i = 0; i < 16; i++) sk_bit(1'b1);
    cs_down();
    repeat (PROG + 20) @(negedge clk);
    do_read(8'd20, 2, 0, "R9 ignored frame");

    send_ctrl(1'b0);
    do_write(8'd30, 16'h7777, "R7 after disable");
    do_read(8'd30, 1, 0, "R7 memory kept");
    send_ctrl(1'b1);

    for (int n = 0; n < 24; n++) begin
      ra = 8'($urandom);
      rd = 16'($urandom);
      case ($urandom % 6)
        0, 1, 2: do_write(ra, rd, "R4 random write");
        3, 4:    do_read(ra, 1 + int'($urandom % 3), int'($urandom % 3), "R1 random read");
        default: send_ctrl(($urandom % 3) != 0);
      endcase
    end
    do_read(8'd254, 4, 1, "R3 final wrap");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule